// File: doc/BRIEF.md
# Three-Product Split Multiplier (34-bit unsigned)

This block multiplies two 34-bit unsigned operands and returns the exact 68-bit product. Each operand is cut into an upper and a lower 17-bit half. Instead of forming the four half-by-half products, the block forms three: the product of the two upper halves, the product of the two lower halves, and the signed product of the two half-differences (upper minus lower for each operand). The cross term is then recovered as the sum of the first two products minus the third. The result is assembled as the upper product shifted by 34, plus the cross term shifted by 17, plus the lower product.

The datapath is a three-stage pipeline. Stage one registers the halves together with the two 18-bit signed differences, so the subtraction sits beside the operand registers and adds no cycle of its own. Stage two holds the three registered products. Stage three holds the recombined output. A new operand pair may be presented on every clock. A valid strobe travels alongside the data.

Top module: `kmul2_top`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the exact unsigned product of the `in_a` and `in_b` values accepted three cycles earlier, over the full 68-bit width, for arbitrary operands.
- R2: The recombined cross term is never negative, even when the product of the two half-differences is negative. One such case is a lower half of `in_a` larger than its upper half while `in_b` has an upper half larger than its lower half. The product stays exact in this case.
- R3: Operands whose two halves are equal make a half-difference of zero, and the product is still exact.
- R4: The corner operands zero and all-ones (0x3_FFFF_FFFF), alone and in combination, give exact products.
- R5: `out_valid` equals `in_valid` delayed by exactly three clock cycles. Idle cycles inside a stream stay idle at the output in the matching positions.
- R6: Operand pairs presented on consecutive cycles are each accepted, and each produces its own result on consecutive cycles.
- R7: The synchronous active-high `rst` clears the valid pipeline. `out_valid` is low in the first cycle after reset is released, and a valid input is needed before any result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 34 | First unsigned operand |
| in_b | input | 34 | Second unsigned operand |
| out_valid | output | 1 | `out_prod` carries a result |
| out_prod | output | 68 | Unsigned product |

## Verification
Every result is due at the third rising edge after the edge that captures its operands. The bench drives inputs on falling edges and pushes a prediction for each driven cycle into a queue that is pre-loaded with three idle entries. On each falling edge it pops one entry, before it drives the next input. The popped entry is therefore the prediction for exactly that cycle, whether the cycle carries data or is idle. The checker compares the output product with the inputs sampled three cycles back. It does this only after three edges free of reset have passed, which it counts itself.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
  localparam int LATENCY = 3;
  localparam int DEF_HALF_W = 17;
endpackage

// File: rtl/kmul_presub.sv
module kmul_presub #(
  parameter int HALF_W = 17
) (
  input  logic                     clk,
  input  logic [2*HALF_W-1:0]      op_a,
  input  logic [2*HALF_W-1:0]      op_b,
  output logic [HALF_W-1:0]        a_hi,
  output logic [HALF_W-1:0]        a_lo,
  output logic [HALF_W-1:0]        b_hi,
  output logic [HALF_W-1:0]        b_lo,
  output logic signed [HALF_W:0]   a_diff,
  output logic signed [HALF_W:0]   b_diff
);
  // halves and their differences share one register stage
  always_ff @(posedge clk) begin
    a_hi   <= op_a[2*HALF_W-1:HALF_W];
    a_lo   <= op_a[HALF_W-1:0];
    b_hi   <= op_b[2*HALF_W-1:HALF_W];
    b_lo   <= op_b[HALF_W-1:0];
    a_diff <= $signed({1'b0, op_a[2*HALF_W-1:HALF_W]}) - $signed({1'b0, op_a[HALF_W-1:0]});
    b_diff <= $signed({1'b0, op_b[2*HALF_W-1:HALF_W]}) - $signed({1'b0, op_b[HALF_W-1:0]});
  end
endmodule

// File: rtl/kmul_mult.sv
module kmul_mult #(
  parameter int  A_W     = 17,
  parameter int  B_W     = 17,
  parameter bit  IS_SIGN = 1'b0
) (
  input  logic               clk,
  input  logic [A_W-1:0]     fa,
  input  logic [B_W-1:0]     fb,
  output logic [A_W+B_W-1:0] prod
);
  generate
    if (IS_SIGN) begin : g_signed
      always_ff @(posedge clk) prod <= $signed(fa) * $signed(fb);
    end else begin : g_unsigned
      always_ff @(posedge clk) prod <= fa * fb;
    end
  endgenerate
endmodule

// File: rtl/kmul_combine.sv
module kmul_combine #(
  parameter int HALF_W = 17
) (
  input  logic                        clk,
  input  logic [2*HALF_W-1:0]         p_hh,
  input  logic [2*HALF_W-1:0]         p_ll,
  input  logic [2*HALF_W+1:0]         p_dd,
  output logic signed [2*HALF_W+2:0]  mid_full,
  output logic [4*HALF_W-1:0]         prod
);
  localparam int MID_W = 2*HALF_W + 1;

  logic [MID_W-1:0] mid_u;

  // cross term = hh + ll - dd; dd is signed and sign-extended by one bit
  always_comb begin
    mid_full = $signed({3'b000, p_hh}) + $signed({3'b000, p_ll})
             - $signed({p_dd[2*HALF_W+1], p_dd});
    mid_u    = mid_full[MID_W-1:0];
  end

  always_ff @(posedge clk) begin
    prod <= {p_hh, {(2*HALF_W){1'b0}}}
          + {{(HALF_W-1){1'b0}}, mid_u, {HALF_W{1'b0}}}
          + {{(2*HALF_W){1'b0}}, p_ll};
  end
endmodule

// File: rtl/kmul2_top.sv
module kmul2_top
  import kmul_pkg::*;
#(
  parameter int HALF_W = DEF_HALF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [2*HALF_W-1:0]   in_a,
  input  logic [2*HALF_W-1:0]   in_b,
  output logic                  out_valid,
  output logic [4*HALF_W-1:0]   out_prod
);
  localparam int OP_W = 2*HALF_W;
  localparam int DP_W = 2*HALF_W + 2;

  logic [HALF_W-1:0]        a_hi, a_lo, b_hi, b_lo;
  logic signed [HALF_W:0]   a_diff, b_diff;
  logic [OP_W-1:0]          p_hh, p_ll;
  logic [DP_W-1:0]          p_dd;
  logic signed [OP_W+2:0]   mid_full;
  logic [LATENCY-1:0]       vpipe;

  kmul_presub #(.HALF_W(HALF_W)) u_pre (
    .clk(clk), .op_a(in_a), .op_b(in_b),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .a_diff(a_diff), .b_diff(b_diff)
  );

  kmul_mult #(.A_W(HALF_W), .B_W(HALF_W), .IS_SIGN(1'b0)) u_mhh (
    .clk(clk), .fa(a_hi), .fb(b_hi), .prod(p_hh)
  );

  kmul_mult #(.A_W(HALF_W), .B_W(HALF_W), .IS_SIGN(1'b0)) u_mll (
    .clk(clk), .fa(a_lo), .fb(b_lo), .prod(p_ll)
  );

  kmul_mult #(.A_W(HALF_W+1), .B_W(HALF_W+1), .IS_SIGN(1'b1)) u_mdd (
    .clk(clk), .fa(a_diff), .fb(b_diff), .prod(p_dd)
  );

  kmul_combine #(.HALF_W(HALF_W)) u_cmb (
    .clk(clk), .p_hh(p_hh), .p_ll(p_ll), .p_dd(p_dd),
    .mid_full(mid_full), .prod(out_prod)
  );

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LATENCY-2:0], in_valid};
  end

  assign out_valid = vpipe[LATENCY-1];
endmodule

// File: rtl/kmul2_chk.sv
module kmul2_chk #(
  parameter int HALF_W = 17
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [2*HALF_W-1:0]        in_a,
  input logic [2*HALF_W-1:0]        in_b,
  input logic                       out_valid,
  input logic [4*HALF_W-1:0]        out_prod,
  input logic                       st2_valid,
  input logic signed [2*HALF_W+2:0] mid_full
);
  logic [1:0] clean_edges;

  always_ff @(posedge clk) begin
    if (rst) clean_edges <= 2'd0;
    else if (clean_edges != 2'd3) clean_edges <= clean_edges + 2'd1;
  end

  // R5: valid strobe delayed by exactly three cycles
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    (clean_edges == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1: exact product of operands seen three cycles before
  a_r1_exact: assert property (@(posedge clk) disable iff (rst)
    (clean_edges == 2'd3 && out_valid) |->
      (out_prod == ({{(2*HALF_W){1'b0}}, $past(in_a, 3)} * {{(2*HALF_W){1'b0}}, $past(in_b, 3)})));

  // R2: recombined cross term never negative
  a_r2_mid_nonneg: assert property (@(posedge clk) disable iff (rst)
    st2_valid |-> (mid_full >= 0));

  // R7: first cycle after reset release shows no result
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

bind kmul2_top kmul2_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_prod(out_prod),
  .st2_valid(vpipe[1]), .mid_full(mid_full)
);

// File: tb/sim_kmul2_top.sv
module sim_kmul2_top;
  localparam int K  = 17;
  localparam int OW = 2*K;
  localparam int PW = 4*K;

  typedef struct {
    bit            v;
    logic [PW-1:0] p;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [OW-1:0] in_a = '0;
  logic [OW-1:0] in_b = '0;
  logic          out_valid;
  logic [PW-1:0] out_prod;

  int   n_chk  = 0;
  int   n_fail = 0;
  int   cycles = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  kmul2_top #(.HALF_W(K)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input bit v, input logic [OW-1:0] a, input logic [OW-1:0] b, input string tag);
    exp_t e;
    exp_t n;
    @(negedge clk);
    e = q.pop_front();
    n_chk++;
    if (out_valid !== e.v) begin
      n_fail++;
      $display("FAIL %s: out_valid actual %0b expected %0b", e.tag, out_valid, e.v);
    end
    if (e.v) begin
      n_chk++;
      if (out_prod !== e.p) begin
        n_fail++;
        $display("FAIL %s: out_prod actual %h expected %h", e.tag, out_prod, e.p);
      end
    end
    in_valid = v;
    in_a = a;
    in_b = b;
    n.v = v;
    n.p = {{OW{1'b0}}, a} * {{OW{1'b0}}, b};
    n.tag = tag;
    q.push_back(n);
  endtask

  function automatic logic [OW-1:0] rnd34();
    return {$urandom, $urandom};
  endfunction

  initial begin
    exp_t idle;
    logic [OW-1:0] ones;
    ones = '1;
    idle.v = 1'b0; idle.p = '0; idle.tag = "R7";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) q.push_back(idle);

    // R4: zero and all-ones corners
    step(1'b1, '0, '0, "R4");
    step(1'b1, '0, ones, "R4");
    step(1'b1, ones, '0, "R4");
    step(1'b1, ones, ones, "R4");
    step(1'b1, ones, 34'd1, "R4");
    // R3: equal halves give zero differences
    step(1'b1, {17'h1ABCD, 17'h1ABCD}, {17'h0F0F0, 17'h0F0F0}, "R3");
    step(1'b1, {17'h1FFFF, 17'h1FFFF}, rnd34(), "R3");
    // R2: lower half of a larger, upper half of b larger
    step(1'b1, {17'h00001, 17'h1FFFF}, {17'h1FFFF, 17'h00001}, "R2");
    step(1'b1, {17'h00000, 17'h1FFFF}, {17'h1FFFF, 17'h00000}, "R2");
    step(1'b1, {17'h12345, 17'h1F000}, {17'h1EEEE, 17'h00777}, "R2");
    // R5: idle gaps within a stream
    step(1'b0, rnd34(), rnd34(), "R5");
    step(1'b1, rnd34(), rnd34(), "R5");
    step(1'b0, rnd34(), rnd34(), "R5");
    step(1'b0, rnd34(), rnd34(), "R5");
    step(1'b1, rnd34(), rnd34(), "R5");
    // R6: back-to-back operands every cycle
    for (int i = 0; i < 40; i++) step(1'b1, rnd34(), rnd34(), "R6");
    // R1: random operands with random gaps
    for (int i = 0; i < 200; i++) step(1'($urandom), rnd34(), rnd34(), "R1");
    // R7: reset in mid-stream clears pending results
    step(1'b1, rnd34(), rnd34(), "R7");
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) q.push_back(idle);
    step(1'b1, ones, ones, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, "R5");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule